// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block produces the serial clock of an I2C controller from a faster source clock. A 24-bit control word holds three 8-bit divider fields: one for the low phase, one for the extension added to every phase, and one for the high phase. When the high field is zero, the high phase uses the low divider, which gives a symmetric clock for standard mode. When the high field is nonzero, the two phases have different lengths, which gives the roughly one-third high, two-thirds low shape used in fast and fast-plus modes (up to 1 MHz). As an example, with a 19.2 MHz source at 100 kHz the low field is 93. At 400 kHz the low field is 28 and the high field is 14.

The output is a drive-low enable for the open-drain SCL pad, plus two single-cycle pulses: one at the start of each low phase and one at the start of each high phase. The pulses let the start/stop and data sequencer shift bits in step with the clock.

When a target stretches the clock, the controller raises `stretch_i`. While it is high, the high-phase count is held. The high phase therefore ends only after the programmed number of cycles in which SCL was seen released. Dropping `enable_i` releases SCL and clears the count. The next enable always begins with a full low phase.

Top module: `scl_clk_gen`

The state machine has four states:
- `ST_IDLE`: disabled, SCL released.
- `ST_LOW`: SCL driven low.
- `ST_HIGH`: SCL released, counting.
- `ST_HOLD`: SCL released, count frozen by stretch.

Its transitions are:
- IDLE→LOW when enable is seen high.
- LOW→HIGH when the low count ends.
- HIGH→HOLD and HOLD→HOLD while stretch is high.
- HOLD→HIGH when stretch falls and the count is not yet done.
- HIGH→LOW and HOLD→LOW when the high count ends with stretch low.
- Any state→IDLE when enable is low.

## Requirements
- R1: While reset is asserted, and in the first cycle after it, SCL is released (`scl_drive_low_o`=0) and both pulses are 0.
- R2: While `enable_i` is sampled low, the next cycle has SCL released and no pulse.
- R3: In the cycle after `enable_i` is first sampled high from idle, SCL is driven low and `scl_fall_o` is 1.
- R4: A low phase lasts (bits 7:0) + E source cycles, where E is the extension defined in R11.
- R5: When bits 23:16 are nonzero, a high phase without stretch lasts (bits 23:16) + E cycles.
- R6: When bits 23:16 are zero, a high phase lasts (bits 7:0) + E cycles, the same as the low phase.
- R7: Each cycle with `stretch_i` sampled high during a high phase adds exactly one cycle to that phase; the count is frozen meanwhile.
- R8: `stretch_i` has no effect on the length of a low phase.
- R9: `scl_rise_o` pulses exactly once per period, in the first released cycle; `scl_fall_o` and `scl_rise_o` are never both 1.
- R10: When `enable_i` drops mid-phase, SCL is released in the next cycle; a following re-enable starts a full low phase.
- R11: The extension E equals bits 15:8 when they are nonzero, and 3 when they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the clock generator |
| stretch_i | input | 1 | SCL seen held low by another device |
| ctrl_i | input | 24 | Divider word: low [7:0], extension [15:8], high [23:16] |
| scl_drive_low_o | output | 1 | 1 = pull SCL low |
| scl_fall_o | output | 1 | Pulse in the first cycle of each low phase |
| scl_rise_o | output | 1 | Pulse in the first cycle of each high phase |

## Verification
Every output is a decode of the state register, so each result appears one clock after the input that caused it. Enabling from idle drives SCL low in the following cycle. Disabling releases SCL in the following cycle. A stretch cycle sampled at one edge shows up as one extra released cycle before the next fall pulse. The bench drives inputs at the falling edge and reads outputs at the next falling edge. It measures each phase by counting consecutive falling-edge samples between the fall and rise pulses. Expected phase lengths are computed from the field values using R4 to R7 and R11.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_HOLD = 2'd3
    } scl_state_e;

    // Field slots inside the control word, each DIV_W bits wide
    localparam int NUM_FIELDS = 3;
    localparam int FLD_LOW    = 0;
    localparam int FLD_EXT    = 1;
    localparam int FLD_HIGH   = 2;

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode
    import scl_div_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_EXT = 3
) (
    input  logic [NUM_FIELDS*DIV_W-1:0] ctrl_i,
    output logic [DIV_W:0]              low_len_o,
    output logic [DIV_W:0]              high_len_o
);

    localparam int LEN_W = DIV_W + 1;

    logic [DIV_W-1:0] fld [NUM_FIELDS];

    generate
        for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
            assign fld[g] = ctrl_i[g*DIV_W +: DIV_W];
        end
    endgenerate

    logic [DIV_W-1:0] ext_sel;
    logic [DIV_W-1:0] high_base;

    always_comb begin
        // Zero extension field falls back to the default offset
        ext_sel    = (fld[FLD_EXT] != '0) ? fld[FLD_EXT] : DIV_W'(DEF_EXT);
        // Zero high field selects a symmetric duty cycle
        high_base  = (fld[FLD_HIGH] != '0) ? fld[FLD_HIGH] : fld[FLD_LOW];
        low_len_o  = LEN_W'(fld[FLD_LOW]) + LEN_W'(ext_sel);
        high_len_o = LEN_W'(high_base) + LEN_W'(ext_sel);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             stretch_i,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output scl_state_e       state_o,
    output logic [LEN_W-1:0] cnt_o,
    output logic             drive_low_o,
    output logic             fall_o,
    output logic             rise_o
);

    scl_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             low_done, high_done;

    assign low_done  = (cnt_q >= (low_len_i - LEN_W'(1)));
    assign high_done = (cnt_q >= (high_len_i - LEN_W'(1)));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and phase counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
                ST_LOW: begin
                    if (low_done) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + LEN_W'(1);
                    end
                end
                ST_HIGH, ST_HOLD: begin
                    if (stretch_i) begin
                        state_d = ST_HOLD;
                    end else if (high_done) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_HIGH;
                        cnt_d   = cnt_q + LEN_W'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        drive_low_o = 1'b0;
        fall_o      = 1'b0;
        rise_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOW: begin
                drive_low_o = 1'b1;
                fall_o      = (cnt_q == '0);
            end
            ST_HIGH: rise_o = (cnt_q == '0);
            ST_HOLD: ;
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_div_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_EXT = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        enable_i,
    input  logic                        stretch_i,
    input  logic [NUM_FIELDS*DIV_W-1:0] ctrl_i,
    output logic                        scl_drive_low_o,
    output logic                        scl_fall_o,
    output logic                        scl_rise_o
);

    localparam int LEN_W = DIV_W + 1;

    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic [LEN_W-1:0] phase_cnt;
    scl_state_e       fsm_state;

    scl_field_decode #(
        .DIV_W  (DIV_W),
        .DEF_EXT(DEF_EXT)
    ) dec_i (
        .ctrl_i    (ctrl_i),
        .low_len_o (low_len),
        .high_len_o(high_len)
    );

    scl_phase_fsm #(
        .LEN_W(LEN_W)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .stretch_i  (stretch_i),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .state_o    (fsm_state),
        .cnt_o      (phase_cnt),
        .drive_low_o(scl_drive_low_o),
        .fall_o     (scl_fall_o),
        .rise_o     (scl_rise_o)
    );

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk
    import scl_div_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             stretch_i,
    input logic             scl_drive_low_o,
    input logic             scl_fall_o,
    input logic             scl_rise_o,
    input scl_state_e       state,
    input logic [LEN_W-1:0] cnt,
    input logic [LEN_W-1:0] low_len
);

    // R2 / R10
    p_off_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!scl_drive_low_o && !scl_fall_o && !scl_rise_o));

    // R3
    p_idle_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE && enable_i) |=> (scl_drive_low_o && scl_fall_o));

    // R7
    p_hold_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state == ST_HIGH || state == ST_HOLD) && enable_i && stretch_i)
        |=> ($stable(cnt) && !scl_drive_low_o));

    // R8
    p_low_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_LOW && enable_i && (({1'b0, cnt} + 1'b1) < {1'b0, low_len}))
        |=> (state == ST_LOW));

    // R9
    p_pulse_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(scl_fall_o && scl_rise_o));

    // R9
    p_rise_after_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_rise_o |-> $past(scl_drive_low_o));

endmodule

bind scl_clk_gen scl_clk_gen_chk #(.LEN_W(DIV_W + 1)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enable_i       (enable_i),
    .stretch_i      (stretch_i),
    .scl_drive_low_o(scl_drive_low_o),
    .scl_fall_o     (scl_fall_o),
    .scl_rise_o     (scl_rise_o),
    .state          (fsm_state),
    .cnt            (phase_cnt),
    .low_len        (low_len)
);

// File: tb/scl_clk_gen_tb.sv
module scl_clk_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        stretch = 1'b0;
    logic [23:0] ctrl = '0;
    logic        drive, fall, rise;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clk_gen dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (enable),
        .stretch_i      (stretch),
        .ctrl_i         (ctrl),
        .scl_drive_low_o(drive),
        .scl_fall_o     (fall),
        .scl_rise_o     (rise)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input int hi, input int ext, input int lo);
        return {hi[7:0], ext[7:0], lo[7:0]};
    endfunction

    // Measure one full period starting at the next fall pulse
    task automatic measure(input int hold_n, input bit hold_low,
                           output int lo, output int hi, output int rises);
        int guard = 0;
        @(negedge clk);
        while (!fall && guard < LIMIT) begin
            guard++;
            @(negedge clk);
        end
        lo = 0;
        hi = 0;
        rises = 0;
        if (hold_low) stretch = 1'b1;
        while (drive && lo < LIMIT) begin
            lo++;
            if (rise) rises++;
            @(negedge clk);
        end
        stretch = 1'b0;
        if (hold_n > 0) stretch = 1'b1;
        while (!fall && hi < LIMIT) begin
            if (rise && fall) rises += 100;
            if (rise) rises++;
            hi++;
            if (hi == hold_n + 1) stretch = 1'b0;
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "drive in reset", drive, 0);
        check("R1", "pulses in reset", fall | rise, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "drive after reset", drive, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2", "drive while disabled", drive, 0);
            check("R2", "pulses while disabled", fall | rise, 0);
        end
    endtask

    task automatic t_enable_std();
        int lo;
        ctrl = mk(0, 3, 5);
        enable = 1'b1;
        @(negedge clk);
        check("R3", "drive after enable", drive, 1);
        check("R3", "fall after enable", fall, 1);
        check("R3", "rise after enable", rise, 0);
        lo = 0;
        while (drive && lo < LIMIT) begin
            lo++;
            @(negedge clk);
        end
        check("R4", "first low length", lo, 8);
    endtask

    task automatic t_period(input string req, input logic [23:0] c,
                            input int exp_lo, input int exp_hi);
        int lo, hi, rises;
        ctrl = c;
        measure(0, 1'b0, lo, hi, rises);
        check(req, "low length", lo, exp_lo);
        check(req, "high length", hi, exp_hi);
        check("R9", "rise pulses per period", rises, 1);
    endtask

    task automatic t_stretch_high();
        int lo, hi, rises;
        ctrl = mk(4, 3, 10);
        measure(5, 1'b0, lo, hi, rises);
        check("R7", "low length", lo, 13);
        check("R7", "stretched high length", hi, 12);
        check("R9", "rise pulses with stretch", rises, 1);
    endtask

    task automatic t_stretch_low();
        int lo, hi, rises;
        ctrl = mk(4, 3, 10);
        measure(0, 1'b1, lo, hi, rises);
        check("R8", "low length under stretch", lo, 13);
        check("R8", "high length after", hi, 7);
    endtask

    task automatic t_disable();
        int lo, hi, rises;
        int guard = 0;
        ctrl = mk(0, 3, 5);
        measure(0, 1'b0, lo, hi, rises);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R10", "drive after disable", drive, 0);
        check("R10", "pulses after disable", fall | rise, 0);
        repeat (3) @(negedge clk);
        check("R2", "still released", drive, 0);
        enable = 1'b1;
        @(negedge clk);
        check("R10", "fall on re-enable", fall, 1);
        lo = 0;
        while (drive && guard < LIMIT) begin
            lo++;
            guard++;
            @(negedge clk);
        end
        check("R10", "full low after re-enable", lo, 8);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_std();
        t_period("R6", mk(0, 3, 5), 8, 8);
        t_period("R5", mk(4, 3, 10), 13, 7);
        t_period("R11", mk(4, 0, 10), 13, 7);
        t_period("R11", mk(4, 5, 10), 15, 9);
        t_period("R4", mk(0, 3, 0), 3, 3);
        t_period("R5", mk(255, 3, 255), 258, 258);
        t_stretch_high();
        t_stretch_low();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule